// File: doc/BRIEF.md
# Device Error Signaling Controller

This block runs the signaling sequence for one error detected inside a PCI Express function. A requester hands it a raw error status word, a flag that says whether the error belongs to the correctable class, a flag that says a non-fatal error may be treated as advisory, and the source ID to report. The block checks the request and sets the device-status detected bits. It updates the correctable and uncorrectable error status words, applies the mask and severity settings, and asks an external header log to record the error. It then decides whether an error message goes upstream and at which severity.

When the header log reports that it is full while a record is requested, and a message was sent, the block runs a second correctable error of type header-log overflow through the same sequence on its own. While a sequence is in progress, `busy` is high and new requests are ignored. Log storage and upstream routing live outside the block.

Top module: `errsig_ctrl`

## Requirements
- R1: The raw status is ANDed with the supported set of its class. The correctable set is 0x0000F1C1 and the uncorrectable set is 0x03FFF030. A result with no bits or with more than one bit set is rejected: `req_reject` pulses for one cycle, and no status, log request or message follows.
- R2: Fatality of an uncorrectable error is the matching `uncor_severity` bit when `aer_present` is 1. When `aer_present` is 0 it comes from a fixed default: bits 4, 5, 13, 17, 18 and 22 are fatal and the other supported bits are non-fatal. With `aer_present` 0, the correctable and uncorrectable status words, the masks and the log request are all unused.
- R3: A correctable error sets `dev_status[0]`. With `aer_present` 1 it also sets its bit in `cor_status`. If that bit is set in `cor_mask`, no message is sent. Otherwise a message of severity 1 is sent when `cor_rpt_en` is 1.
- R4: With `aer_present` 1, an uncorrectable error whose bit is set in `uncor_mask` sets its `uncor_status` bit and its detected bit, and produces no log request and no message. The detected bit is `dev_status[2]` if the error is fatal and `dev_status[1]` if it is not.
- R5: With `aer_present` 1, an unmasked uncorrectable error pulses `log_req` with `log_status` equal to the one-hot error bit, and sets its `uncor_status` bit. A fatal message (severity 3) needs `serr_en` or `fatal_rpt_en`. A non-fatal message (severity 2) needs `serr_en` or `nonfatal_rpt_en`.
- R6: The unsupported-request error (uncorrectable bit 20) also sets `dev_status[3]`. On the uncorrectable path its message is suppressed unless `ur_rpt_en` or `serr_en` is 1. On the advisory path its message needs `ur_rpt_en`.
- R7: A non-fatal uncorrectable error with `req_advisory_ok` set is handled as the correctable advisory non-fatal error, bit 13. It sets `dev_status[0]` and `cor_status` bit 13. If bit 13 is set in `cor_mask`, nothing further happens. Otherwise the original bit is set in `uncor_status`, it is logged only if it is clear in `uncor_mask`, and a severity 1 message follows the rules of R3 and R6.
- R8: A follow-up correctable error, bit 15, is sequenced when three things hold in the same sequence: a log request was made, `log_full` was high, and a message was sent. The follow-up carries the same source ID and can produce a second severity 1 message.
- R9: A request is accepted when `req_valid` is high and `busy` is low. `busy` stays high until the sequence and any follow-up finish, and requests during that time are ignored. Each message is a one-cycle `msg_valid` pulse with `msg_source` equal to the accepted source ID.
- R10: After reset all status words, `dev_status`, `busy`, `msg_valid`, `log_req` and `req_reject` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Error request strobe |
| req_status | input | 32 | Raw error status, one bit expected |
| req_correctable | input | 1 | Request belongs to the correctable class |
| req_advisory_ok | input | 1 | Non-fatal error may be handled as advisory |
| req_source | input | SRC_W | Requester ID to report |
| aer_present | input | 1 | Advanced reporting registers are implemented |
| cor_rpt_en | input | 1 | Correctable reporting enable |
| nonfatal_rpt_en | input | 1 | Non-fatal reporting enable |
| fatal_rpt_en | input | 1 | Fatal reporting enable |
| ur_rpt_en | input | 1 | Unsupported-request reporting enable |
| serr_en | input | 1 | System error enable |
| cor_mask | input | 32 | Correctable mask |
| uncor_mask | input | 32 | Uncorrectable mask |
| uncor_severity | input | 32 | Uncorrectable severity, 1 = fatal |
| log_full | input | 1 | Header log cannot take the requested record |
| busy | output | 1 | Sequence in progress |
| req_reject | output | 1 | Invalid request pulse |
| dev_status | output | 4 | Detected bits: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| cor_status | output | 32 | Sticky correctable status |
| uncor_status | output | 32 | Sticky uncorrectable status |
| log_req | output | 1 | Record request to the header log |
| log_status | output | 32 | One-hot error being recorded |
| msg_valid | output | 1 | Error message strobe |
| msg_sev | output | 2 | Message severity: 1 correctable, 2 non-fatal, 3 fatal |
| msg_source | output | SRC_W | Source ID of the message |

## Verification
The bench targets several corner cases. A masked advisory error must leave the uncorrectable status untouched; a design that sets it anyway shows a wrong `uncor_status`. An unsupported request that `serr_en` alone may let through on the uncorrectable path must still be blocked on the advisory path, and a design that mixes the two rules sends or drops the wrong message. A full log must trigger the overflow follow-up only when a message went out; a design that gets this wrong shows a missing or extra second message and a wrong `cor_status` bit 15. Multi-bit and unsupported-bit requests, the default severity table with the capability absent, and a request held high during `busy` show up as wrong reject, log or message counts.

// File: rtl/errsig_pkg.sv
package errsig_pkg;

    localparam int STW = 32;

    localparam logic [STW-1:0] COR_SUP       = 32'h0000_F1C1;
    localparam logic [STW-1:0] UNC_SUP       = 32'h03FF_F030;
    localparam logic [STW-1:0] UNC_DEF_FATAL = 32'h0046_2030;
    localparam logic [STW-1:0] UNC_UR        = 32'h0010_0000;
    localparam logic [STW-1:0] COR_ADVISORY  = 32'h0000_2000;
    localparam logic [STW-1:0] COR_HLOG_OVF  = 32'h0000_8000;

    localparam int DET_W   = 4;
    localparam int DET_COR = 0;
    localparam int DET_NF  = 1;
    localparam int DET_FAT = 2;
    localparam int DET_UR  = 3;

    typedef enum logic [1:0] {
        SEV_NONE     = 2'd0,
        SEV_COR      = 2'd1,
        SEV_NONFATAL = 2'd2,
        SEV_FATAL    = 2'd3
    } sev_e;

    typedef struct packed {
        logic           ok;
        logic [STW-1:0] bits;
        logic           fatal;
        logic           ur;
    } cls_t;

    typedef struct packed {
        logic [STW-1:0]   cor_set;
        logic [STW-1:0]   unc_set;
        logic [DET_W-1:0] det_set;
        logic             rec;
        logic             send;
        sev_e             sev;
        logic             followup;
    } upd_t;

endpackage

// File: rtl/errsig_classify.sv
module errsig_classify
    import errsig_pkg::*;
(
    input  logic [STW-1:0] raw,
    input  logic           is_cor,
    input  logic           aer_on,
    input  logic [STW-1:0] sev_reg,
    output cls_t           cls
);

    logic [STW-1:0] kept;
    logic [STW-1:0] fatal_sel;

    always_comb begin
        kept      = raw & (is_cor ? COR_SUP : UNC_SUP);
        fatal_sel = aer_on ? sev_reg : UNC_DEF_FATAL;
        cls.ok    = (kept != '0) && ((kept & (kept - 1'b1)) == '0);
        cls.bits  = kept;
        cls.fatal = !is_cor && ((kept & fatal_sel) != '0);
        cls.ur    = !is_cor && (kept == UNC_UR);
    end

endmodule

// File: rtl/errsig_decide.sv
module errsig_decide
    import errsig_pkg::*;
(
    input  cls_t           cls,
    input  logic           is_cor,
    input  logic           adv_ok,
    input  logic           aer_on,
    input  logic           cor_en,
    input  logic           nf_en,
    input  logic           fat_en,
    input  logic           ur_en,
    input  logic           serr,
    input  logic [STW-1:0] cmask,
    input  logic [STW-1:0] umask,
    input  logic           log_full,
    output upd_t           upd
);

    logic           take_cor;
    logic [STW-1:0] cbits;
    logic           masked;
    logic           permit;

    always_comb begin
        upd      = '0;
        masked   = 1'b0;
        permit   = 1'b0;
        take_cor = is_cor || (!cls.fatal && adv_ok);
        cbits    = is_cor ? cls.bits : COR_ADVISORY;

        if (take_cor) begin
            upd.det_set[DET_COR] = 1'b1;
            upd.det_set[DET_UR]  = cls.ur;
            if (aer_on) begin
                upd.cor_set = cbits;
                if ((cmask & cbits) != '0) begin
                    masked = 1'b1;
                end else if (!is_cor) begin
                    upd.unc_set = cls.bits;
                    upd.rec     = ((umask & cls.bits) == '0);
                end
            end
            permit  = !masked && cor_en && (!cls.ur || ur_en);
            upd.sev = SEV_COR;
        end else begin
            upd.det_set[DET_FAT] = cls.fatal;
            upd.det_set[DET_NF]  = !cls.fatal;
            upd.det_set[DET_UR]  = cls.ur;
            if (aer_on) begin
                upd.unc_set = cls.bits;
                if ((umask & cls.bits) != '0) begin
                    masked = 1'b1;
                end else begin
                    upd.rec = 1'b1;
                end
            end
            permit  = !masked
                      && !(cls.ur && !ur_en && !serr)
                      && (serr || (cls.fatal ? fat_en : nf_en));
            upd.sev = cls.fatal ? SEV_FATAL : SEV_NONFATAL;
        end

        upd.send     = cls.ok && permit;
        upd.rec      = cls.ok && upd.rec;
        upd.followup = upd.send && upd.rec && log_full;
        if (!cls.ok) begin
            upd.cor_set = '0;
            upd.unc_set = '0;
            upd.det_set = '0;
        end
    end

endmodule

// File: rtl/errsig_ctrl.sv
module errsig_ctrl
    import errsig_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_status,
    input  logic             req_correctable,
    input  logic             req_advisory_ok,
    input  logic [SRC_W-1:0] req_source,
    input  logic             aer_present,
    input  logic             cor_rpt_en,
    input  logic             nonfatal_rpt_en,
    input  logic             fatal_rpt_en,
    input  logic             ur_rpt_en,
    input  logic             serr_en,
    input  logic [31:0]      cor_mask,
    input  logic [31:0]      uncor_mask,
    input  logic [31:0]      uncor_severity,
    input  logic             log_full,
    output logic             busy,
    output logic             req_reject,
    output logic [3:0]       dev_status,
    output logic [31:0]      cor_status,
    output logic [31:0]      uncor_status,
    output logic             log_req,
    output logic [31:0]      log_status,
    output logic             msg_valid,
    output logic [1:0]       msg_sev,
    output logic [SRC_W-1:0] msg_source
);

    typedef enum logic { S_IDLE, S_EVAL } phase_e;

    typedef struct packed {
        phase_e           phase;
        logic [STW-1:0]   p_status;
        logic             p_cor;
        logic             p_adv;
        logic [SRC_W-1:0] p_src;
        logic [STW-1:0]   cor_sta;
        logic [STW-1:0]   unc_sta;
        logic [DET_W-1:0] det;
        logic             mv;
        sev_e             msev;
        logic [SRC_W-1:0] msrc;
        logic             rej;
    } regs_t;

    regs_t r_d, r_q;
    cls_t  cls;
    upd_t  upd;

    errsig_classify u_classify (
        .raw     (r_q.p_status),
        .is_cor  (r_q.p_cor),
        .aer_on  (aer_present),
        .sev_reg (uncor_severity),
        .cls     (cls)
    );

    errsig_decide u_decide (
        .cls      (cls),
        .is_cor   (r_q.p_cor),
        .adv_ok   (r_q.p_adv),
        .aer_on   (aer_present),
        .cor_en   (cor_rpt_en),
        .nf_en    (nonfatal_rpt_en),
        .fat_en   (fatal_rpt_en),
        .ur_en    (ur_rpt_en),
        .serr     (serr_en),
        .cmask    (cor_mask),
        .umask    (uncor_mask),
        .log_full (log_full),
        .upd      (upd)
    );

    always_comb begin
        r_d     = r_q;
        r_d.mv  = 1'b0;
        r_d.rej = 1'b0;
        case (r_q.phase)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.phase    = S_EVAL;
                    r_d.p_status = req_status;
                    r_d.p_cor    = req_correctable;
                    r_d.p_adv    = req_advisory_ok;
                    r_d.p_src    = req_source;
                end
            end
            S_EVAL: begin
                if (!cls.ok) begin
                    r_d.rej   = 1'b1;
                    r_d.phase = S_IDLE;
                end else begin
                    r_d.cor_sta = r_q.cor_sta | upd.cor_set;
                    r_d.unc_sta = r_q.unc_sta | upd.unc_set;
                    r_d.det     = r_q.det | upd.det_set;
                    r_d.mv      = upd.send;
                    if (upd.send) begin
                        r_d.msev = upd.sev;
                        r_d.msrc = r_q.p_src;
                    end
                    if (upd.followup) begin
                        r_d.p_status = COR_HLOG_OVF;
                        r_d.p_cor    = 1'b1;
                        r_d.p_adv    = 1'b0;
                    end else begin
                        r_d.phase = S_IDLE;
                    end
                end
            end
            default: r_d.phase = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.phase == S_EVAL);
    assign req_reject   = r_q.rej;
    assign dev_status   = r_q.det;
    assign cor_status   = r_q.cor_sta;
    assign uncor_status = r_q.unc_sta;
    assign log_req      = (r_q.phase == S_EVAL) && upd.rec;
    assign log_status   = cls.bits;
    assign msg_valid    = r_q.mv;
    assign msg_sev      = r_q.msev;
    assign msg_source   = r_q.msrc;

endmodule

// File: rtl/errsig_chk.sv
module errsig_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        req_reject,
    input logic [31:0] cor_status,
    input logic [31:0] uncor_status,
    input logic        log_req,
    input logic [31:0] log_status,
    input logic        msg_valid,
    input logic [1:0]  msg_sev
);

    // R9
    msg_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(busy));

    // R9
    log_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> busy);

    // R5
    log_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> ($countones(log_status) == 1));

    // R1
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (!msg_valid && $stable(cor_status) && $stable(uncor_status)));

    // R3
    cor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cor_status & $past(cor_status)) == $past(cor_status)));

    // R4
    unc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((uncor_status & $past(uncor_status)) == $past(uncor_status)));

    // R8
    msg_sev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_sev != 2'd0));

endmodule

bind errsig_ctrl errsig_chk u_errsig_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .req_reject   (req_reject),
    .cor_status   (cor_status),
    .uncor_status (uncor_status),
    .log_req      (log_req),
    .log_status   (log_status),
    .msg_valid    (msg_valid),
    .msg_sev      (msg_sev)
);

// File: tb/errsig_ctrl_test.sv
`timescale 1ns/1ps
module errsig_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_status = '0;
    logic        req_correctable = 1'b0;
    logic        req_advisory_ok = 1'b0;
    logic [15:0] req_source = '0;
    logic        aer_present = 1'b1;
    logic        cor_rpt_en = 1'b0, nonfatal_rpt_en = 1'b0, fatal_rpt_en = 1'b0;
    logic        ur_rpt_en = 1'b0, serr_en = 1'b0;
    logic [31:0] cor_mask = '0, uncor_mask = '0, uncor_severity = '0;
    logic        log_full = 1'b0;
    logic        busy, req_reject, log_req, msg_valid;
    logic [3:0]  dev_status;
    logic [31:0] cor_status, uncor_status, log_status;
    logic [1:0]  msg_sev;
    logic [15:0] msg_source;

    errsig_ctrl #(.SRC_W(16)) uut (.*);

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    int mon_msg = 0, mon_rec = 0, mon_rej = 0;
    logic [1:0]  mon_sev;
    logic [15:0] mon_src;
    logic [31:0] mon_rst;

    always @(negedge clk) begin
        if (msg_valid) begin mon_msg++; mon_sev = msg_sev; mon_src = msg_source; end
        if (log_req)   begin mon_rec++; mon_rst = log_status; end
        if (req_reject) mon_rej++;
    end

    // model state
    logic [31:0] m_cor, m_unc;
    logic [3:0]  m_det;
    int          e_msg, e_rec, e_rej;
    logic [1:0]  e_sev;
    logic [31:0] e_rst;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_eval(input logic [31:0] raw, input bit cor, input bit adv, output bit ovf);
        logic [31:0] bits, cb, fsel;
        bit fatal, ur, msk, rec, send;
        logic [1:0] sev;
        ovf  = 0;
        bits = raw & (cor ? 32'h0000_F1C1 : 32'h03FF_F030);
        if ($countones(bits) != 1) begin e_rej++; return; end
        fsel  = aer_present ? uncor_severity : 32'h0046_2030;
        fatal = !cor && ((bits & fsel) != 0);
        ur    = !cor && (bits == 32'h0010_0000);
        msk = 0; rec = 0;
        if (cor || (!fatal && adv)) begin
            cb = cor ? bits : 32'h0000_2000;
            m_det[0] = 1'b1;
            if (ur) m_det[3] = 1'b1;
            if (aer_present) begin
                m_cor |= cb;
                if ((cor_mask & cb) != 0) msk = 1;
                else if (!cor) begin
                    if ((uncor_mask & bits) == 0) rec = 1;
                    m_unc |= bits;
                end
            end
            send = !msk && cor_rpt_en && (!ur || ur_rpt_en);
            sev  = 2'd1;
        end else begin
            if (fatal) m_det[2] = 1'b1; else m_det[1] = 1'b1;
            if (ur) m_det[3] = 1'b1;
            if (aer_present) begin
                m_unc |= bits;
                if ((uncor_mask & bits) != 0) msk = 1; else rec = 1;
            end
            send = !msk && !(ur && !ur_rpt_en && !serr_en)
                   && (serr_en || (fatal ? fatal_rpt_en : nonfatal_rpt_en));
            sev  = fatal ? 2'd3 : 2'd2;
        end
        if (rec) begin e_rec++; e_rst = bits; end
        if (send) begin e_msg++; e_sev = sev; end
        ovf = send && rec && log_full;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_cor = '0; m_unc = '0; m_det = '0;
        @(negedge clk);
    endtask

    task automatic trial(string tag, logic [31:0] raw, bit cor, bit adv,
                         logic [15:0] src, bit hold);
        int b_msg, b_rec, b_rej, guard;
        bit o1, o2;
        e_msg = 0; e_rec = 0; e_rej = 0;
        m_eval(raw, cor, adv, o1);
        if (o1) m_eval(32'h0000_8000, 1'b1, 1'b0, o2);
        b_msg = mon_msg; b_rec = mon_rec; b_rej = mon_rej;
        req_status = raw; req_correctable = cor; req_advisory_ok = adv;
        req_source = src; req_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            req_status = 32'h0000_0001; req_correctable = 1'b1; req_source = ~src;
        end else req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (busy && guard < 20) begin @(negedge clk); guard++; end
        @(negedge clk);
        check({tag, " msg count"}, mon_msg - b_msg, e_msg);
        if (e_msg > 0) begin
            check({tag, " msg sev"}, {30'd0, mon_sev}, {30'd0, e_sev});
            check({tag, " R9 msg source"}, {16'd0, mon_src}, {16'd0, src});
        end
        check({tag, " log count"}, mon_rec - b_rec, e_rec);
        if (e_rec > 0) check({tag, " log status"}, mon_rst, e_rst);
        check({tag, " R1 reject count"}, mon_rej - b_rej, e_rej);
        check({tag, " cor_status"}, cor_status, m_cor);
        check({tag, " uncor_status"}, uncor_status, m_unc);
        check({tag, " dev_status"}, {28'd0, dev_status}, {28'd0, m_det});
    endtask

    task automatic set_cfg(bit aer, bit ce, bit ne, bit fe, bit ue, bit se,
                           logic [31:0] cm, logic [31:0] um, logic [31:0] sv, bit full);
        aer_present = aer; cor_rpt_en = ce; nonfatal_rpt_en = ne; fatal_rpt_en = fe;
        ur_rpt_en = ue; serr_en = se; cor_mask = cm; uncor_mask = um;
        uncor_severity = sv; log_full = full;
    endtask

    function automatic logic [31:0] pick_bit(bit cor);
        int idx;
        if (cor) begin
            idx = $urandom % 8;
            case (idx)
                0: return 32'h1; 1: return 32'h40; 2: return 32'h80; 3: return 32'h100;
                default: return 32'h1 << (12 + idx - 4);
            endcase
        end
        idx = $urandom % 16;
        if (idx < 2) return 32'h1 << (4 + idx);
        return 32'h1 << (12 + idx - 2);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005_EED1));
        do_reset();
        // R10 reset state
        check("R10 busy", {31'd0, busy}, 0);
        check("R10 cor_status", cor_status, 0);
        check("R10 uncor_status", uncor_status, 0);
        check("R10 dev_status", {28'd0, dev_status}, 0);
        check("R10 msg_valid", {31'd0, msg_valid}, 0);
        check("R10 log_req", {31'd0, log_req}, 0);

        // R1 invalid requests
        set_cfg(1,1,1,1,1,1, 0,0,0,0);
        trial("R1 two bits", 32'h0000_0030, 0, 0, 16'h0101, 0);
        trial("R1 unsupported bit", 32'h0000_0002, 0, 0, 16'h0102, 0);
        trial("R1 zero cor", 32'h0000_0010, 1, 0, 16'h0103, 0);

        // R2 default table without capability: bit 4 fatal, bit 12 not
        set_cfg(0,1,1,1,0,0, 32'hFFFF_FFFF,32'hFFFF_FFFF,0,1);
        trial("R2 default fatal", 32'h0000_0010, 0, 0, 16'h0201, 0);
        trial("R2 default nonfatal", 32'h0000_1000, 0, 0, 16'h0202, 0);
        do_reset();
        // R2 severity register selects
        set_cfg(1,1,1,1,0,0, 0,0,32'h0000_1000,0);
        trial("R2 sev reg fatal", 32'h0000_1000, 0, 0, 16'h0203, 0);

        // R3 correctable masked and unmasked
        set_cfg(1,1,0,0,0,0, 32'h0000_0040,0,0,0);
        trial("R3 cor masked", 32'h0000_0040, 1, 0, 16'h0301, 0);
        trial("R3 cor sent", 32'h0000_0080, 1, 0, 16'h0302, 0);

        // R4 uncorrectable masked
        set_cfg(1,1,1,1,1,1, 0,32'h0000_4000,0,0);
        trial("R4 unc masked", 32'h0000_4000, 0, 0, 16'h0401, 0);

        // R5 enables
        set_cfg(1,0,1,0,0,0, 0,0,32'h0004_0000,0);
        trial("R5 fatal no enable", 32'h0004_0000, 0, 0, 16'h0501, 0);
        trial("R5 nonfatal enable", 32'h0000_8000, 0, 0, 16'h0502, 0);

        // R6 unsupported request
        do_reset();
        set_cfg(1,1,0,0,0,1, 0,0,0,0);
        trial("R6 ur via serr", 32'h0010_0000, 0, 0, 16'h0601, 0);
        do_reset();
        trial("R6 ur advisory blocked", 32'h0010_0000, 0, 1, 16'h0602, 0);

        // R7 advisory: masked in cor mask, then unmasked
        do_reset();
        set_cfg(1,1,0,0,0,0, 32'h0000_2000,0,0,0);
        trial("R7 advisory cor masked", 32'h0001_0000, 0, 1, 16'h0701, 0);
        set_cfg(1,1,0,0,0,0, 0,32'h0000_8000,0,0);
        trial("R7 advisory unc masked", 32'h0000_8000, 0, 1, 16'h0702, 0);

        // R8 overflow follow-up, and no follow-up without a message
        do_reset();
        set_cfg(1,1,1,1,0,0, 0,0,0,1);
        trial("R8 overflow", 32'h0000_1000, 0, 0, 16'h0801, 0);
        do_reset();
        set_cfg(1,1,0,0,0,0, 0,0,0,1);
        trial("R8 no msg no follow", 32'h0000_1000, 0, 0, 16'h0802, 0);

        // R9 request held while busy is ignored
        do_reset();
        set_cfg(1,1,1,1,0,0, 0,0,0,1);
        trial("R9 hold busy ovf", 32'h0000_2000, 0, 0, 16'h0901, 1);
        set_cfg(1,1,1,1,0,0, 0,0,0,0);
        trial("R9 hold busy", 32'h0002_0000, 0, 0, 16'h0902, 1);

        // random mix
        for (int i = 0; i < 240; i++) begin
            logic [31:0] raw;
            bit cor;
            if (i % 12 == 0) do_reset();
            cor = $urandom % 2;
            raw = ($urandom % 5 == 0) ? $urandom : pick_bit(cor);
            set_cfg(($urandom % 5) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                    $urandom % 2, $urandom % 2,
                    $urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                    $urandom, ($urandom % 3) == 0);
            trial(cor ? "R3 rand" : "R5 rand", raw, cor, $urandom % 2,
                  16'($urandom), ($urandom % 4) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule